// File: doc/BRIEF.md
# PTP Real-Time Clock

This block is a free-running time-of-day counter used as the time base for IEEE 1588 timestamping. It keeps a 48-bit seconds count and a sub-second accumulator whose unit is 1/256 of a nanosecond. On every cycle of the timing clock the accumulator grows by a programmable increment. It wraps at the fixed value of one second (256,000,000,000 units), and each wrap adds one to the seconds count. Because the increment has fractional-nanosecond resolution, clock frequencies that do not divide a nanosecond evenly still keep exact average time.

A small CPU-side register file sits in a separate clock domain. Software writes a staged time or a staged increment and then issues an adjust command. The command toggles across to the timing domain, where it takes effect on a single edge. A done flag returns for software to poll. A snapshot command captures the running time into holding registers, also through a toggle handshake, so software reads a coherent seconds/nanoseconds pair. A registered output presents the time in standard PTP form (48-bit seconds, 32-bit nanoseconds) to neighbouring logic.

Top module: `ptp_rtc`

## Requirements
- R1: While `rtcRstN` is low, `ptpSec` and `ptpNs` read 0. After `cpuRstN` is released, the status word (address 0) reads 0 and the staged increment (address 4) reads 0.
- R2: Each `rtcClk` cycle, the accumulator grows by the increment, counted in 1/256 ns. `ptpNs` is the accumulator divided by 256, rounded down. The increment after interface reset is 2048 (8 ns per cycle). An increment of 2176 gives per-cycle steps of 8 or 9 ns that total 17 ns over two cycles.
- R3: When accumulator plus increment reaches 256,000,000,000, the seconds count increases by one and the excess is kept. A count of 0x1_FFFF_FFFF carries correctly to 0x2_0000_0000.
- R4: Writing address 0 with bit 0 set loads the staged seconds (address 1 = upper 16 bits in data bits 15:0, address 2 = lower 32 bits) and the staged nanoseconds (address 3) on one `rtcClk` edge. No increment is added on that edge.
- R5: Writing address 0 with bit 1 set replaces the increment with the value staged at address 4. The new value applies from the next edge onward.
- R6: Status bit 0 (adjust done) clears when an adjust command is accepted. It sets only after the adjustment has taken effect. A new adjust command is ignored while one is pending.
- R7: Writing address 0 with bit 2 set captures the running time. Status bit 1 (snapshot done) clears on the command and sets once the capture has finished. Reads of addresses 1, 2 and 3 then return the captured upper seconds, lower seconds and nanoseconds. The captured time lies between the output times seen before the request and after the done flag.
- R8: A pulse on `rtcRstN` clears the time but keeps the programmed increment.
- R9: `ptpSec`/`ptpNs` are registered. A loaded time appears at the output one cycle after the load edge, and the next cycle shows it advanced by one increment.
- R10: Reading address 4 returns the last value written there.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| rtcClk | input | 1 | Timing clock that advances the time |
| rtcRstN | input | 1 | Active-low asynchronous reset of the time count only |
| cpuClk | input | 1 | Register-interface clock |
| cpuRstN | input | 1 | Active-low asynchronous reset of registers, handshakes and increment |
| cpuWrEn | input | 1 | Register write strobe |
| cpuAddr | input | 3 | Register word address |
| cpuWrData | input | 32 | Register write data |
| cpuRdData | output | 32 | Register read data (combinational from `cpuAddr`) |
| ptpSec | output | 48 | PTP-format seconds |
| ptpNs | output | 32 | PTP-format nanoseconds |

## Verification
The hardest situation to reach is the exact load edge. It happens a few synchronizer cycles after the CPU write, at an `rtcClk` edge the bench cannot know in advance. The bench watches the time output every timing cycle after the command. It takes the first cycle that shows the loaded seconds as the load, and then requires the exact staged nanoseconds there and exactly one increment more on the following cycle. The seconds carry is reached by loading a time just under a second boundary, with a seconds value whose lower 32 bits are all ones. The bench then follows the output until the wrap and checks the kept remainder.

// File: rtl/ptp_rtc_pkg.sv
package ptp_rtc_pkg;

  localparam int CPU_W = 32;
  localparam longint NS_PER_SEC = 64'd1_000_000_000;

  typedef struct packed {
    logic loadTime;
    logic loadInc;
    logic capture;
  } rtcStrobe_t;

endpackage

// File: rtl/ptp_rtc_sync.sv
module ptp_rtc_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic d,
  output logic q
);

  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) chain <= '0;
    else       chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];

endmodule

// File: rtl/ptp_rtc_dp.sv
module ptp_rtc_dp
  import ptp_rtc_pkg::*;
#(
  parameter int SEC_W   = 48,
  parameter int NS_W    = 32,
  parameter int FRAC_W  = 8,
  parameter int INC_W   = 32,
  parameter int DEF_INC = 2048
) (
  input  logic             rtcClk,
  input  logic             rtcRstN,
  input  logic             ifRstN,
  input  rtcStrobe_t       stb,
  input  logic [SEC_W-1:0] setSec,
  input  logic [NS_W-1:0]  setNs,
  input  logic [INC_W-1:0] setInc,
  output logic [SEC_W-1:0] snapSec,
  output logic [NS_W-1:0]  snapNs,
  output logic [SEC_W-1:0] ptpSec,
  output logic [NS_W-1:0]  ptpNs
);

  localparam logic [63:0]    MOD64   = 64'(NS_PER_SEC) << FRAC_W;
  localparam int             ACC_W   = $clog2(MOD64);
  localparam logic [ACC_W:0] MOD_EXT = (ACC_W+1)'(MOD64);

  logic [ACC_W-1:0] acc;
  logic [SEC_W-1:0] secCnt;
  logic [INC_W-1:0] incReg;
  logic [ACC_W:0]   sumFull;
  logic             wrap;
  logic [ACC_W-1:0] accNext;
  logic [ACC_W-1:0] accLoad;
  logic [NS_W-1:0]  nsNow;

  always_comb begin
    sumFull = {1'b0, acc} + {{(ACC_W+1-INC_W){1'b0}}, incReg};
    wrap    = (sumFull >= MOD_EXT);
    accNext = wrap ? ACC_W'(sumFull - MOD_EXT) : ACC_W'(sumFull);
    accLoad = ACC_W'(setNs) << FRAC_W;
    nsNow   = NS_W'(acc >> FRAC_W);
  end

  // increment survives a time reset
  always_ff @(posedge rtcClk or negedge ifRstN) begin
    if (!ifRstN)          incReg <= INC_W'(DEF_INC);
    else if (stb.loadInc) incReg <= setInc;
  end

  always_ff @(posedge rtcClk or negedge rtcRstN) begin
    if (!rtcRstN) begin
      acc    <= '0;
      secCnt <= '0;
    end else if (stb.loadTime) begin
      acc    <= accLoad;
      secCnt <= setSec;
    end else begin
      acc    <= accNext;
      secCnt <= secCnt + SEC_W'(wrap);
    end
  end

  // output pipeline stage
  always_ff @(posedge rtcClk or negedge rtcRstN) begin
    if (!rtcRstN) begin
      ptpSec <= '0;
      ptpNs  <= '0;
    end else begin
      ptpSec <= secCnt;
      ptpNs  <= nsNow;
    end
  end

  always_ff @(posedge rtcClk or negedge rtcRstN) begin
    if (!rtcRstN) begin
      snapSec <= '0;
      snapNs  <= '0;
    end else if (stb.capture) begin
      snapSec <= secCnt;
      snapNs  <= nsNow;
    end
  end

  assert_acc_below_mod_R3: assert property (@(posedge rtcClk) disable iff (!rtcRstN)
    {1'b0, acc} < MOD_EXT);

  assert_sec_step_R3: assert property (@(posedge rtcClk) disable iff (!rtcRstN)
    !stb.loadTime |=> (secCnt == $past(secCnt)) || (secCnt == $past(secCnt) + 1'b1));

  assert_load_time_R4: assert property (@(posedge rtcClk) disable iff (!rtcRstN)
    stb.loadTime |=> (secCnt == $past(setSec)) && (NS_W'(acc >> FRAC_W) == $past(setNs)));

  assert_load_inc_R5: assert property (@(posedge rtcClk) disable iff (!ifRstN)
    stb.loadInc |=> incReg == $past(setInc));

endmodule

// File: rtl/ptp_rtc_ctrl.sv
module ptp_rtc_ctrl
  import ptp_rtc_pkg::*;
#(
  parameter int SEC_W       = 48,
  parameter int NS_W        = 32,
  parameter int INC_W       = 32,
  parameter int ADDR_W      = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic              cpuClk,
  input  logic              cpuRstN,
  input  logic              rtcClk,
  input  logic              cpuWrEn,
  input  logic [ADDR_W-1:0] cpuAddr,
  input  logic [CPU_W-1:0]  cpuWrData,
  output logic [CPU_W-1:0]  cpuRdData,
  input  logic [SEC_W-1:0]  snapSec,
  input  logic [NS_W-1:0]   snapNs,
  output logic [SEC_W-1:0]  stageSec,
  output logic [NS_W-1:0]   stageNs,
  output logic [INC_W-1:0]  stageInc,
  output rtcStrobe_t        stb
);

  localparam logic [ADDR_W-1:0] ADR_CMD   = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] ADR_SECHI = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] ADR_SECLO = ADDR_W'(2);
  localparam logic [ADDR_W-1:0] ADR_NS    = ADDR_W'(3);
  localparam logic [ADDR_W-1:0] ADR_INC   = ADDR_W'(4);
  localparam int HI_W = SEC_W - CPU_W;

  // cpu domain state
  logic modeTime, modeInc;
  logic adjReqTgl, snapReqTgl;
  logic adjAckSync, snapAckSync;
  logic adjAckSeen, snapAckSeen;
  logic adjDone, snapDone;
  logic adjBusy, snapBusy;
  logic adjAckPulse, snapAckPulse;

  // rtc domain state
  logic adjReqSync, snapReqSync;
  logic adjReqSeen, snapReqSeen;
  logic adjPulse, snapPulse;
  logic adjApplied, snapApplied;
  logic adjAckTgl, snapAckTgl;

  assign adjBusy      = adjReqTgl ^ adjAckSeen;
  assign snapBusy     = snapReqTgl ^ snapAckSeen;
  assign adjAckPulse  = adjAckSync ^ adjAckSeen;
  assign snapAckPulse = snapAckSync ^ snapAckSeen;

  always_ff @(posedge cpuClk or negedge cpuRstN) begin
    if (!cpuRstN) begin
      stageSec    <= '0;
      stageNs     <= '0;
      stageInc    <= '0;
      modeTime    <= 1'b0;
      modeInc     <= 1'b0;
      adjReqTgl   <= 1'b0;
      snapReqTgl  <= 1'b0;
      adjAckSeen  <= 1'b0;
      snapAckSeen <= 1'b0;
      adjDone     <= 1'b0;
      snapDone    <= 1'b0;
    end else begin
      adjAckSeen  <= adjAckSync;
      snapAckSeen <= snapAckSync;
      if (adjAckPulse)  adjDone  <= 1'b1;
      if (snapAckPulse) snapDone <= 1'b1;
      if (cpuWrEn) begin
        case (cpuAddr)
          ADR_CMD: begin
            if ((cpuWrData[0] || cpuWrData[1]) && !adjBusy) begin
              modeTime  <= cpuWrData[0];
              modeInc   <= cpuWrData[1];
              adjReqTgl <= ~adjReqTgl;
              adjDone   <= 1'b0;
            end
            if (cpuWrData[2] && !snapBusy) begin
              snapReqTgl <= ~snapReqTgl;
              snapDone   <= 1'b0;
            end
          end
          ADR_SECHI: stageSec[SEC_W-1:CPU_W] <= cpuWrData[HI_W-1:0];
          ADR_SECLO: stageSec[CPU_W-1:0]     <= cpuWrData;
          ADR_NS:    stageNs                 <= cpuWrData[NS_W-1:0];
          ADR_INC:   stageInc                <= cpuWrData[INC_W-1:0];
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    case (cpuAddr)
      ADR_CMD:   cpuRdData = {{(CPU_W-2){1'b0}}, snapDone, adjDone};
      ADR_SECHI: cpuRdData = CPU_W'(snapSec[SEC_W-1:CPU_W]);
      ADR_SECLO: cpuRdData = snapSec[CPU_W-1:0];
      ADR_NS:    cpuRdData = CPU_W'(snapNs);
      ADR_INC:   cpuRdData = CPU_W'(stageInc);
      default:   cpuRdData = '0;
    endcase
  end

  ptp_rtc_sync #(.STAGES(SYNC_STAGES)) u_adjReqSync (
    .clk(rtcClk), .rstN(cpuRstN), .d(adjReqTgl), .q(adjReqSync));
  ptp_rtc_sync #(.STAGES(SYNC_STAGES)) u_snapReqSync (
    .clk(rtcClk), .rstN(cpuRstN), .d(snapReqTgl), .q(snapReqSync));
  ptp_rtc_sync #(.STAGES(SYNC_STAGES)) u_adjAckSync (
    .clk(cpuClk), .rstN(cpuRstN), .d(adjAckTgl), .q(adjAckSync));
  ptp_rtc_sync #(.STAGES(SYNC_STAGES)) u_snapAckSync (
    .clk(cpuClk), .rstN(cpuRstN), .d(snapAckTgl), .q(snapAckSync));

  assign adjPulse  = adjReqSync ^ adjReqSeen;
  assign snapPulse = snapReqSync ^ snapReqSeen;

  always_ff @(posedge rtcClk or negedge cpuRstN) begin
    if (!cpuRstN) begin
      adjReqSeen  <= 1'b0;
      snapReqSeen <= 1'b0;
      adjApplied  <= 1'b0;
      snapApplied <= 1'b0;
      adjAckTgl   <= 1'b0;
      snapAckTgl  <= 1'b0;
    end else begin
      adjReqSeen  <= adjReqSync;
      snapReqSeen <= snapReqSync;
      adjApplied  <= adjPulse;
      snapApplied <= snapPulse;
      if (adjApplied)  adjAckTgl  <= ~adjAckTgl;
      if (snapApplied) snapAckTgl <= ~snapAckTgl;
    end
  end

  // mode bits are held stable by the busy lock while a request is in flight
  assign stb.loadTime = adjPulse & modeTime;
  assign stb.loadInc  = adjPulse & modeInc;
  assign stb.capture  = snapPulse;

  assert_one_apply_R4: assert property (@(posedge rtcClk) disable iff (!cpuRstN)
    adjPulse |=> !adjPulse);

  assert_done_idle_R6: assert property (@(posedge cpuClk) disable iff (!cpuRstN)
    adjDone |-> !adjBusy);

  assert_snap_idle_R7: assert property (@(posedge cpuClk) disable iff (!cpuRstN)
    snapDone |-> !snapBusy);

endmodule

// File: rtl/ptp_rtc.sv
module ptp_rtc
  import ptp_rtc_pkg::*;
#(
  parameter int SEC_W       = 48,
  parameter int NS_W        = 32,
  parameter int FRAC_W      = 8,
  parameter int INC_W       = 32,
  parameter int DEF_INC     = 2048,
  parameter int ADDR_W      = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic              rtcClk,
  input  logic              rtcRstN,
  input  logic              cpuClk,
  input  logic              cpuRstN,
  input  logic              cpuWrEn,
  input  logic [ADDR_W-1:0] cpuAddr,
  input  logic [CPU_W-1:0]  cpuWrData,
  output logic [CPU_W-1:0]  cpuRdData,
  output logic [SEC_W-1:0]  ptpSec,
  output logic [NS_W-1:0]   ptpNs
);

  rtcStrobe_t       stb;
  logic [SEC_W-1:0] stageSec, snapSec;
  logic [NS_W-1:0]  stageNs, snapNs;
  logic [INC_W-1:0] stageInc;

  ptp_rtc_ctrl #(
    .SEC_W(SEC_W), .NS_W(NS_W), .INC_W(INC_W),
    .ADDR_W(ADDR_W), .SYNC_STAGES(SYNC_STAGES)
  ) u_ctrl (
    .cpuClk(cpuClk), .cpuRstN(cpuRstN), .rtcClk(rtcClk),
    .cpuWrEn(cpuWrEn), .cpuAddr(cpuAddr), .cpuWrData(cpuWrData),
    .cpuRdData(cpuRdData), .snapSec(snapSec), .snapNs(snapNs),
    .stageSec(stageSec), .stageNs(stageNs), .stageInc(stageInc),
    .stb(stb)
  );

  ptp_rtc_dp #(
    .SEC_W(SEC_W), .NS_W(NS_W), .FRAC_W(FRAC_W),
    .INC_W(INC_W), .DEF_INC(DEF_INC)
  ) u_dp (
    .rtcClk(rtcClk), .rtcRstN(rtcRstN), .ifRstN(cpuRstN), .stb(stb),
    .setSec(stageSec), .setNs(stageNs), .setInc(stageInc),
    .snapSec(snapSec), .snapNs(snapNs), .ptpSec(ptpSec), .ptpNs(ptpNs)
  );

endmodule

// File: tb/ptp_rtc_bench.sv
module ptp_rtc_bench;

  logic        rtcClk = 1'b0;
  logic        cpuClk = 1'b0;
  logic        rtcRstN = 1'b0;
  logic        cpuRstN = 1'b0;
  logic        cpuWrEn = 1'b0;
  logic [2:0]  cpuAddr = '0;
  logic [31:0] cpuWrData = '0;
  logic [31:0] cpuRdData;
  logic [47:0] ptpSec;
  logic [31:0] ptpNs;

  int checks = 0;
  int errors = 0;

  always #5 rtcClk = ~rtcClk;
  always #7.5 cpuClk = ~cpuClk;

  ptp_rtc u_ptp_rtc (
    .rtcClk(rtcClk), .rtcRstN(rtcRstN), .cpuClk(cpuClk), .cpuRstN(cpuRstN),
    .cpuWrEn(cpuWrEn), .cpuAddr(cpuAddr), .cpuWrData(cpuWrData),
    .cpuRdData(cpuRdData), .ptpSec(ptpSec), .ptpNs(ptpNs)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cpuWrite(input logic [2:0] a, input logic [31:0] d);
    @(negedge cpuClk);
    cpuWrEn = 1'b1; cpuAddr = a; cpuWrData = d;
    @(negedge cpuClk);
    cpuWrEn = 1'b0;
  endtask

  task automatic cpuRead(input logic [2:0] a, output logic [31:0] d);
    @(negedge cpuClk);
    cpuAddr = a;
    #1 d = cpuRdData;
  endtask

  task automatic pollBit(input int idx, input string req);
    logic [31:0] s;
    bit seen = 1'b0;
    for (int i = 0; i < 60 && !seen; i++) begin
      cpuRead(3'd0, s);
      seen = s[idx];
    end
    check(seen, req, longint'(seen), 1);
  endtask

  function automatic longint nowNs();
    return longint'(ptpSec) * 64'd1_000_000_000 + longint'(ptpNs);
  endfunction

  task automatic t_reset();
    logic [31:0] d;
    @(negedge rtcClk);
    check(ptpSec == 0, "R1 sec in reset", longint'(ptpSec), 0);
    check(ptpNs == 0, "R1 ns in reset", longint'(ptpNs), 0);
    cpuRstN = 1'b1;
    rtcRstN = 1'b1;
    cpuRead(3'd0, d);
    check(d == 0, "R1 status after reset", longint'(d), 0);
    cpuRead(3'd4, d);
    check(d == 0, "R1 staged increment after reset", longint'(d), 0);
  endtask

  task automatic t_advance();
    longint n0;
    repeat (3) @(negedge rtcClk);
    n0 = longint'(ptpNs);
    repeat (10) @(negedge rtcClk);
    check(longint'(ptpNs) - n0 == 80, "R2 default step 8ns", longint'(ptpNs) - n0, 80);
  endtask

  task automatic t_loadTime();
    logic [31:0] d;
    bit found = 1'b0;
    longint prev;
    cpuWrite(3'd1, 32'h0000_0001);
    cpuWrite(3'd2, 32'hFFFF_FFFF);
    cpuWrite(3'd3, 32'd999_999_001);
    cpuWrite(3'd0, 32'h1);
    cpuRead(3'd0, d);
    check(d[0] == 1'b0, "R6 done cleared by command", longint'(d[0]), 0);
    for (int i = 0; i < 100 && !found; i++) begin
      @(negedge rtcClk);
      found = (ptpSec == 48'h1_FFFF_FFFF);
    end
    check(found, "R4 loaded seconds seen", longint'(found), 1);
    check(ptpNs == 32'd999_999_001, "R4 loaded ns exact", longint'(ptpNs), 999_999_001);
    @(negedge rtcClk);
    check(ptpNs == 32'd999_999_009, "R9 one increment after load", longint'(ptpNs), 999_999_009);
    pollBit(0, "R6 adjust done");
    check(ptpSec == 48'h1_FFFF_FFFF, "R6 done after effect", longint'(ptpSec), 48'h1_FFFF_FFFF);
    found = 1'b0;
    prev = longint'(ptpNs);
    for (int i = 0; i < 300 && !found; i++) begin
      prev = longint'(ptpNs);
      @(negedge rtcClk);
      found = (ptpSec != 48'h1_FFFF_FFFF);
    end
    check(ptpSec == 48'h2_0000_0000, "R3 seconds carry", longint'(ptpSec), 48'h2_0000_0000);
    check(ptpNs == 1, "R3 remainder kept", longint'(ptpNs), 1);
    check(prev == 999_999_993, "R3 last ns before wrap", prev, 999_999_993);
  endtask

  task automatic t_loadInc();
    logic [31:0] d;
    longint n0;
    cpuWrite(3'd4, 32'd4096);
    cpuRead(3'd4, d);
    check(d == 32'd4096, "R10 staged increment readback", longint'(d), 4096);
    cpuWrite(3'd0, 32'h2);
    pollBit(0, "R6 done after increment load");
    @(negedge rtcClk);
    n0 = longint'(ptpNs);
    repeat (5) @(negedge rtcClk);
    check(longint'(ptpNs) - n0 == 80, "R5 new increment 16ns", longint'(ptpNs) - n0, 80);
  endtask

  task automatic t_rtcReset();
    longint n0;
    @(negedge rtcClk);
    rtcRstN = 1'b0;
    repeat (2) @(negedge rtcClk);
    check(ptpSec == 0 && ptpNs == 0, "R8 time cleared", longint'(ptpNs), 0);
    rtcRstN = 1'b1;
    repeat (3) @(negedge rtcClk);
    n0 = longint'(ptpNs);
    @(negedge rtcClk);
    check(longint'(ptpNs) - n0 == 16, "R8 increment kept", longint'(ptpNs) - n0, 16);
    check(ptpSec == 0, "R8 seconds restart", longint'(ptpSec), 0);
  endtask

  task automatic t_snapshot();
    logic [31:0] d, hi, lo, ns;
    longint t0, t1, s;
    @(negedge rtcClk);
    t0 = nowNs();
    cpuWrite(3'd0, 32'h4);
    cpuRead(3'd0, d);
    check(d[1] == 1'b0, "R7 snap done cleared", longint'(d[1]), 0);
    pollBit(1, "R7 snap done");
    @(negedge rtcClk);
    t1 = nowNs();
    cpuRead(3'd1, hi);
    cpuRead(3'd2, lo);
    cpuRead(3'd3, ns);
    s = (longint'({hi[15:0], lo}) * 64'd1_000_000_000) + longint'(ns);
    check(s >= t0, "R7 snapshot not before request", s, t0);
    check(s <= t1, "R7 snapshot not after done", s, t1);
    cpuWrite(3'd1, 32'h0000_0003);
    cpuWrite(3'd2, 32'h0000_0007);
    cpuWrite(3'd3, 32'd500);
    cpuWrite(3'd0, 32'h1);
    pollBit(0, "R6 done for second load");
    cpuWrite(3'd0, 32'h4);
    pollBit(1, "R7 second snap done");
    cpuRead(3'd1, hi);
    cpuRead(3'd2, lo);
    cpuRead(3'd3, ns);
    check(hi == 32'd3, "R7 upper seconds word", longint'(hi), 3);
    check(lo == 32'd7, "R7 lower seconds word", longint'(lo), 7);
    check(ns >= 32'd500 && ns < 32'd5000, "R7 ns near loaded value", longint'(ns), 500);
  endtask

  task automatic t_frac();
    longint n0, n1, n2;
    cpuWrite(3'd4, 32'd2176);
    cpuWrite(3'd0, 32'h2);
    pollBit(0, "R6 done for fractional increment");
    repeat (2) @(negedge rtcClk);
    n0 = longint'(ptpNs);
    @(negedge rtcClk);
    n1 = longint'(ptpNs);
    @(negedge rtcClk);
    n2 = longint'(ptpNs);
    check(n1 - n0 == 8 || n1 - n0 == 9, "R2 fractional step A", n1 - n0, 8);
    check(n2 - n1 == 8 || n2 - n1 == 9, "R2 fractional step B", n2 - n1, 8);
    check(n2 - n0 == 17, "R2 fractional two-step total", n2 - n0, 17);
  endtask

  initial begin
    repeat (3) @(negedge cpuClk);
    t_reset();
    t_advance();
    t_loadTime();
    t_loadInc();
    t_rtcReset();
    t_snapshot();
    t_frac();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #1_000_000;
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule